// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block handles in-band flow control for a UART. It sits between the receive deserializer and the receive FIFO, and between the transmit FIFO and the serializer. On the receive path it compares every accepted character with four programmable flow characters. A matching stop character pauses outgoing data, and a matching start character lets data flow again. Matched flow characters are absorbed and never reach the receive FIFO. On the transmit path it watches two indications of receive-FIFO pressure. When the halt indication appears it sends a stop character once, and when the resume indication follows it sends a start character once. Injected characters always go ahead of queued data.

Both data paths are valid/ready streams. A character on the receive input is taken when `rx_valid_i` and `rx_ready_o` are both high. A flow character that is absorbed is always accepted, whatever the state of the downstream ready. Any other character passes straight through to `fwd_*` and waits for `fwd_ready_i`. On the transmit side, a data character is taken only while `ser_ready_i` is high, no injection is in progress, and transmission is allowed.

A 4-bit mode field splits into two 2-bit pair selectors. Bits [1:0] choose what the receiver compares, and bits [3:2] choose what the transmitter generates. In both selectors, 00 means off, 01 means pair 2, 10 means pair 1, and 11 means both pairs used as a two-character sequence.

Top module: `swf_ctrl`

## Requirements
- R1: After reset, `tx_allow_o` is 1, `ser_valid_o` is 0 unless data is offered, and `stat_o` is 0.
- R2: With `flow_en_i`=1 and receiver selector 10, an accepted XOFF1 clears `tx_allow_o` from the next cycle, and an accepted XON1 sets it. Characters equal to XON2 or XOFF2 are forwarded and have no effect.
- R3: With receiver selector 01, XOFF2 and XON2 stop and restart transmission in the same way, and pair-1 characters are forwarded.
- R4: With receiver selector 11, all four characters are absorbed. Transmission stops only when XOFF1 is immediately followed by XOFF2, and restarts only when XON1 is immediately followed by XON2. A broken pair has no effect on `tx_allow_o`.
- R5: With receiver selector 00, or with `flow_en_i`=0, no character is absorbed and `tx_allow_o` stays 1.
- R6: An absorbed character gives `fwd_valid_o`=0 and `rx_ready_o`=1, even when `fwd_ready_i`=0. Any other character gives `fwd_valid_o`=1 and `rx_ready_o`=`fwd_ready_i`.
- R7: Each accepted character sets the status bits it equals, in any mode: bit 0 XON1, bit 1 XON2, bit 2 XOFF1, bit 3 XOFF2. A `rx_break_i` pulse sets bit 4. A `stat_clr_i` pulse clears all bits in the next cycle, but a new event in the same cycle wins.
- R8: Outgoing data reaches `ser_valid_o` only while `tx_allow_o` is 1, and `tx_ready_o` is never 1 while `tx_allow_o` is 0.
- R9: With transmitter selector 01, 10 or 11, the first cycle in which `lvl_halt_i` is sampled high starts an injection of XOFF2, XOFF1, or XOFF1 then XOFF2, respectively. Holding halt high sends nothing more. Selector 00 never injects.
- R10: Once a stop has been sent, `lvl_resume_i` injects the matching start (XON2, XON1, or XON1 then XON2) exactly once. Resume without an earlier stop injects nothing. A later halt injects a stop again.
- R11: While an injection is pending, `ser_data_o` carries the flow character and `tx_ready_o` is 0, so the injection goes ahead of waiting data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flow_en_i | input | 1 | Master enable for automatic software flow control |
| mode_i | input | 4 | [1:0] receiver pair selector, [3:2] transmitter pair selector |
| xon1_i | input | 8 | Start character, pair 1 |
| xon2_i | input | 8 | Start character, pair 2 |
| xoff1_i | input | 8 | Stop character, pair 1 |
| xoff2_i | input | 8 | Stop character, pair 2 |
| rx_valid_i | input | 1 | Received character valid |
| rx_data_i | input | 8 | Received character |
| rx_ready_o | output | 1 | Received character accepted |
| fwd_valid_o | output | 1 | Character forwarded to the receive FIFO |
| fwd_data_o | output | 8 | Forwarded character |
| fwd_ready_i | input | 1 | Receive FIFO can take a character |
| rx_break_i | input | 1 | Break-received strobe |
| stat_clr_i | input | 1 | Status read strobe (clears status) |
| stat_o | output | 5 | Special-character status flags |
| lvl_halt_i | input | 1 | Receive level has reached the halt threshold |
| lvl_resume_i | input | 1 | Receive level is back at the resume threshold |
| tx_valid_i | input | 1 | Outgoing data character valid |
| tx_data_i | input | 8 | Outgoing data character |
| tx_ready_o | output | 1 | Outgoing data character taken |
| ser_valid_o | output | 1 | Character to the serializer valid |
| ser_data_o | output | 8 | Character to the serializer |
| ser_ready_i | input | 1 | Serializer can take a character |
| tx_allow_o | output | 1 | Outgoing data permitted |

## Verification
The hardest situation to reach is selector 11, where the outcome depends on the character accepted just before. The stimulus therefore runs one fixed character string through every receiver selector, and that string contains complete pairs, pairs broken by an ordinary character, and lone second halves. The bench models the pairing rule itself to predict `tx_allow_o`. The second hard case is an injection arriving while data is already waiting. To create it, the serializer is held not-ready while halt rises, so the flow character must displace a character that is already being offered.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_P2   = 2'b01,
    SEL_P1   = 2'b10,
    SEL_BOTH = 2'b11
  } pair_sel_e;

  // hit vector bit positions, shared with the status flags
  localparam int HIT_ON1  = 0;
  localparam int HIT_ON2  = 1;
  localparam int HIT_OFF1 = 2;
  localparam int HIT_OFF2 = 3;
  localparam int NCHARS   = 4;
endpackage

// File: rtl/swf_char_cmp.sv
module swf_char_cmp #(
  parameter int CW = 8
) (
  input  logic [CW-1:0]                 data_i,
  input  logic [swf_pkg::NCHARS*CW-1:0] chars_i,
  output logic [swf_pkg::NCHARS-1:0]    hit_o
);
  for (genvar g = 0; g < swf_pkg::NCHARS; g++) begin : g_cmp
    assign hit_o[g] = (data_i == chars_i[g*CW +: CW]);
  end
endmodule

// File: rtl/swf_rx_match.sv
module swf_rx_match
  import swf_pkg::*;
#(
  parameter int SW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  pair_sel_e       sel_i,
  input  logic [NCHARS-1:0] hit_i,
  input  logic            rx_valid_i,
  input  logic            fwd_ready_i,
  input  logic            brk_i,
  input  logic            clr_i,
  output logic            rx_ready_o,
  output logic            fwd_valid_o,
  output logic            allow_o,
  output logic [SW-1:0]   stat_o
);
  logic flow_char, consume, accept;
  logic allow_q, prev_on1_q, prev_off1_q;
  logic [SW-1:0] stat_q;

  always_comb begin
    unique case (sel_i)
      SEL_P1:   flow_char = hit_i[HIT_ON1] | hit_i[HIT_OFF1];
      SEL_P2:   flow_char = hit_i[HIT_ON2] | hit_i[HIT_OFF2];
      SEL_BOTH: flow_char = |hit_i;
      default:  flow_char = 1'b0;
    endcase
  end

  assign consume     = en_i & flow_char;
  assign rx_ready_o  = consume | fwd_ready_i;
  assign fwd_valid_o = rx_valid_i & ~consume;
  assign accept      = rx_valid_i & rx_ready_o;
  assign allow_o     = allow_q | ~en_i | (sel_i == SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q     <= 1'b1;
      prev_on1_q  <= 1'b0;
      prev_off1_q <= 1'b0;
    end else if (accept) begin
      prev_on1_q  <= hit_i[HIT_ON1];
      prev_off1_q <= hit_i[HIT_OFF1];
      if (consume) begin
        unique case (sel_i)
          SEL_P1: begin
            if (hit_i[HIT_OFF1])     allow_q <= 1'b0;
            else if (hit_i[HIT_ON1]) allow_q <= 1'b1;
          end
          SEL_P2: begin
            if (hit_i[HIT_OFF2])     allow_q <= 1'b0;
            else if (hit_i[HIT_ON2]) allow_q <= 1'b1;
          end
          SEL_BOTH: begin
            if (hit_i[HIT_OFF2] && prev_off1_q)    allow_q <= 1'b0;
            else if (hit_i[HIT_ON2] && prev_on1_q) allow_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      logic [SW-1:0] nxt;
      nxt = clr_i ? '0 : stat_q;
      if (accept) nxt[NCHARS-1:0] = nxt[NCHARS-1:0] | hit_i;
      if (brk_i)  nxt[SW-1] = 1'b1;
      stat_q <= nxt;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/swf_tx_inject.sv
module swf_tx_inject
  import swf_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  pair_sel_e     sel_i,
  input  logic          halt_i,
  input  logic          resume_i,
  input  logic [CW-1:0] on1_i,
  input  logic [CW-1:0] on2_i,
  input  logic [CW-1:0] off1_i,
  input  logic [CW-1:0] off2_i,
  input  logic          allow_i,
  input  logic          tx_valid_i,
  input  logic [CW-1:0] tx_data_i,
  output logic          tx_ready_o,
  input  logic          ser_ready_i,
  output logic          ser_valid_o,
  output logic [CW-1:0] ser_data_o
);
  logic      busy_q, stop_q, second_q, peer_held_q;
  pair_sel_e pair_q;
  logic [CW-1:0] inj_char;
  logic      can_start, last_char;

  assign can_start = ~busy_q & en_i & (sel_i != SEL_NONE);
  assign last_char = second_q | (pair_q != SEL_BOTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      stop_q      <= 1'b0;
      second_q    <= 1'b0;
      peer_held_q <= 1'b0;
      pair_q      <= SEL_NONE;
    end else if (can_start && ((halt_i && !peer_held_q) || (resume_i && peer_held_q))) begin
      busy_q      <= 1'b1;
      stop_q      <= ~peer_held_q;
      peer_held_q <= ~peer_held_q;
      pair_q      <= sel_i;
      second_q    <= (sel_i == SEL_P2);
    end else if (busy_q && ser_ready_i) begin
      if (last_char) busy_q <= 1'b0;
      else           second_q <= 1'b1;
    end
  end

  always_comb begin
    if (stop_q) inj_char = second_q ? off2_i : off1_i;
    else        inj_char = second_q ? on2_i  : on1_i;
  end

  assign ser_valid_o = busy_q | (tx_valid_i & allow_i);
  assign ser_data_o  = busy_q ? inj_char : tx_data_i;
  assign tx_ready_o  = ~busy_q & allow_i & ser_ready_i;
endmodule

// File: rtl/swf_ctrl.sv
module swf_ctrl
  import swf_pkg::*;
#(
  parameter int CW = 8,
  localparam int SW = NCHARS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flow_en_i,
  input  logic [3:0]    mode_i,
  input  logic [CW-1:0] xon1_i,
  input  logic [CW-1:0] xon2_i,
  input  logic [CW-1:0] xoff1_i,
  input  logic [CW-1:0] xoff2_i,
  input  logic          rx_valid_i,
  input  logic [CW-1:0] rx_data_i,
  output logic          rx_ready_o,
  output logic          fwd_valid_o,
  output logic [CW-1:0] fwd_data_o,
  input  logic          fwd_ready_i,
  input  logic          rx_break_i,
  input  logic          stat_clr_i,
  output logic [SW-1:0] stat_o,
  input  logic          lvl_halt_i,
  input  logic          lvl_resume_i,
  input  logic          tx_valid_i,
  input  logic [CW-1:0] tx_data_i,
  output logic          tx_ready_o,
  output logic          ser_valid_o,
  output logic [CW-1:0] ser_data_o,
  input  logic          ser_ready_i,
  output logic          tx_allow_o
);
  logic [NCHARS-1:0]    hit;
  logic [NCHARS*CW-1:0] chars;
  pair_sel_e            rx_sel, tx_sel;
  logic                 allow;

  assign chars  = {xoff2_i, xoff1_i, xon2_i, xon1_i};
  assign rx_sel = pair_sel_e'(mode_i[1:0]);
  assign tx_sel = pair_sel_e'(mode_i[3:2]);

  swf_char_cmp #(.CW(CW)) u_cmp (
    .data_i (rx_data_i),
    .chars_i(chars),
    .hit_o  (hit)
  );

  swf_rx_match #(.SW(SW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (flow_en_i),
    .sel_i      (rx_sel),
    .hit_i      (hit),
    .rx_valid_i (rx_valid_i),
    .fwd_ready_i(fwd_ready_i),
    .brk_i      (rx_break_i),
    .clr_i      (stat_clr_i),
    .rx_ready_o (rx_ready_o),
    .fwd_valid_o(fwd_valid_o),
    .allow_o    (allow),
    .stat_o     (stat_o)
  );

  swf_tx_inject #(.CW(CW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (flow_en_i),
    .sel_i      (tx_sel),
    .halt_i     (lvl_halt_i),
    .resume_i   (lvl_resume_i),
    .on1_i      (xon1_i),
    .on2_i      (xon2_i),
    .off1_i     (xoff1_i),
    .off2_i     (xoff2_i),
    .allow_i    (allow),
    .tx_valid_i (tx_valid_i),
    .tx_data_i  (tx_data_i),
    .tx_ready_o (tx_ready_o),
    .ser_ready_i(ser_ready_i),
    .ser_valid_o(ser_valid_o),
    .ser_data_o (ser_data_o)
  );

  assign fwd_data_o = rx_data_i;
  assign tx_allow_o = allow;
endmodule

// File: rtl/swf_ctrl_chk.sv
module swf_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flow_en_i,
  input logic [3:0] mode_i,
  input logic [7:0] xoff1_i,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       rx_ready_o,
  input logic       fwd_valid_o,
  input logic       rx_break_i,
  input logic       stat_clr_i,
  input logic [4:0] stat_o,
  input logic       tx_ready_o,
  input logic       tx_allow_o
);
  // R2
  xoff1_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en_i && mode_i[1:0] == 2'b10 && rx_valid_i && rx_ready_o && rx_data_i == xoff1_i)
    |=> (!tx_allow_o || mode_i[1:0] == 2'b00 || !flow_en_i));

  // R6
  absorbed_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !fwd_valid_o) |-> rx_ready_o);

  // R6
  fwd_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o |-> rx_valid_i);

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !rx_valid_i && !rx_break_i) |=> (stat_o == 5'd0));

  // R8
  gated_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> tx_allow_o);

  // R5
  disabled_allows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_en_i || mode_i[1:0] == 2'b00) |-> (tx_allow_o && (!rx_valid_i || fwd_valid_o)));
endmodule

bind swf_ctrl swf_ctrl_chk u_chk (.*);

// File: tb/swf_ctrl_test.sv
module swf_ctrl_test;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h12, OFF1 = 8'h13, OFF2 = 8'h14, DAT = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flow_en = 1'b1;
  logic [3:0] mode = 4'd0;
  logic rx_valid = 0, fwd_ready = 1, rx_break = 0, stat_clr = 0;
  logic [7:0] rx_data = 8'h00;
  logic halt = 0, resume = 0, tx_valid = 0, ser_ready = 0;
  logic [7:0] tx_data = DAT;
  logic rx_ready, fwd_valid, tx_ready, ser_valid, tx_allow;
  logic [7:0] fwd_data, ser_data;
  logic [4:0] stat;
  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  swf_ctrl uut (
    .clk(clk), .rst_n(rst_n), .flow_en_i(flow_en), .mode_i(mode),
    .xon1_i(ON1), .xon2_i(ON2), .xoff1_i(OFF1), .xoff2_i(OFF2),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data), .fwd_ready_i(fwd_ready),
    .rx_break_i(rx_break), .stat_clr_i(stat_clr), .stat_o(stat),
    .lvl_halt_i(halt), .lvl_resume_i(resume),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .ser_valid_o(ser_valid), .ser_data_o(ser_data), .ser_ready_i(ser_ready),
    .tx_allow_o(tx_allow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  function automatic logic [7:0] inj(input int tm, input bit stop, input int k);
    logic [7:0] a, b;
    a = stop ? OFF1 : ON1;
    b = stop ? OFF2 : ON2;
    if (tm == 1) return b;
    if (tm == 2) return a;
    return (k == 0) ? a : b;
  endfunction

  // Steps through one injection; the first character is already visible.
  task automatic expect_inject(input string req, input int tm, input bit stop);
    chk(req, {ser_valid, ser_data, tx_ready}, {1'b1, inj(tm, stop, 0), 1'b0});
    tick();
    if (tm == 3) begin
      chk(req, {ser_valid, ser_data}, {1'b1, inj(tm, stop, 1)});
      tick();
    end
  endtask

  logic [7:0] seq [14] = '{8'h13, 8'h14, 8'h41, 8'h11, 8'h12, 8'h13, 8'h41,
                           8'h14, 8'h11, 8'h12, 8'h14, 8'h13, 8'h14, 8'h12};

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    do_reset();
    // R1 reset state
    chk("R1", {tx_allow, ser_valid, stat}, {1'b1, 1'b0, 5'd0});

    // Receive sweep: cfg 0..3 enabled selectors, cfg 4 disabled with selector 11
    for (int cfg = 0; cfg < 5; cfg++) begin
      int rm;
      bit en, allow, pon, poff, cons;
      logic [4:0] st;
      rm = (cfg == 4) ? 3 : cfg;
      en = (cfg != 4);
      flow_en = en;
      mode = {2'b00, rm[1:0]};
      do_reset();
      tx_valid = 1; ser_ready = 0;
      allow = 1; pon = 0; poff = 0; st = '0;
      for (int i = 0; i < 14; i++) begin
        logic [7:0] x;
        string rq;
        x = seq[i];
        rq = (!en || rm == 0) ? "R5" : (rm == 1) ? "R3" : (rm == 2) ? "R2" : "R4";
        cons = 0;
        if (en) begin
          if (rm == 1) cons = (x == ON2) || (x == OFF2);
          if (rm == 2) cons = (x == ON1) || (x == OFF1);
          if (rm == 3) cons = (x == ON1) || (x == ON2) || (x == OFF1) || (x == OFF2);
        end
        rx_valid = 1; rx_data = x;
        #1;
        // R6 absorbed characters are not forwarded
        chk("R6", {fwd_valid, rx_ready}, {!cons, 1'b1});
        tick();
        rx_valid = 0;
        if (cons) begin
          if (rm == 1) begin
            if (x == OFF2) allow = 0; else if (x == ON2) allow = 1;
          end else if (rm == 2) begin
            if (x == OFF1) allow = 0; else if (x == ON1) allow = 1;
          end else if (rm == 3) begin
            if (x == OFF2 && poff) allow = 0; else if (x == ON2 && pon) allow = 1;
          end
        end
        pon = (x == ON1); poff = (x == OFF1);
        st[3:0] = st[3:0] | {x == OFF2, x == OFF1, x == ON2, x == ON1};
        #1;
        chk(rq, tx_allow, (en && rm != 0) ? allow : 1'b1);
        // R8 data offered only when allowed
        chk("R8", ser_valid, (en && rm != 0) ? allow : 1'b1);
        // R7 status flags
        chk("R7", stat, st);
      end
      stat_clr = 1; tick(); stat_clr = 0;
      chk("R7", stat, 5'd0);
    end

    // R6 back-pressure on a forwarded character, absorbed one ignores it
    flow_en = 1; mode = 4'b0010; do_reset();
    fwd_ready = 0; rx_valid = 1; rx_data = 8'h41; #1;
    chk("R6", {fwd_valid, rx_ready, fwd_data}, {1'b1, 1'b0, 8'h41});
    tick();
    chk("R7", stat, 5'd0);
    rx_data = OFF1; #1;
    chk("R6", {fwd_valid, rx_ready}, {1'b0, 1'b1});
    tick(); rx_valid = 0; fwd_ready = 1; #1;
    chk("R2", tx_allow, 1'b0);
    chk("R8", {ser_valid, tx_ready}, 2'b00);

    // R7 break flag and set-wins-over-clear
    do_reset();
    rx_break = 1; tick(); rx_break = 0;
    chk("R7", stat, 5'b10000);
    stat_clr = 1; rx_valid = 1; rx_data = ON2; tick();
    stat_clr = 0; rx_valid = 0;
    chk("R7", stat, 5'b00010);

    // Transmit sweep over generator selectors
    for (int tm = 0; tm < 4; tm++) begin
      flow_en = 1; mode = {tm[1:0], 2'b00};
      do_reset();
      tx_valid = 1; tx_data = DAT; ser_ready = 1;
      // R10 resume with no earlier stop sends nothing
      resume = 1; tick(); resume = 0;
      chk("R10", {ser_valid, ser_data, tx_ready}, {1'b1, DAT, 1'b1});
      ser_ready = 0; halt = 1; tick(); ser_ready = 1; #1;
      if (tm == 0) begin
        chk("R9", {ser_valid, ser_data}, {1'b1, DAT});
      end else begin
        // R11 injection displaces waiting data
        expect_inject("R11", tm, 1'b1);
        for (int k = 0; k < 3; k++) begin
          chk("R9", {ser_valid, ser_data, tx_ready}, {1'b1, DAT, 1'b1});
          tick();
        end
        halt = 0; resume = 1; tick();
        expect_inject("R10", tm, 1'b0);
        for (int k = 0; k < 2; k++) begin
          chk("R10", {ser_data, tx_ready}, {DAT, 1'b1});
          tick();
        end
        resume = 0; halt = 1; tick();
        expect_inject("R9", tm, 1'b1);
      end
      halt = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule